// File: doc/BRIEF.md
# Bit-Stuffing Justification FIFO

This block is a one-bit-wide elastic buffer. It carries a low-order tributary stream (a DS1, E1 or DS2 bit stream) from the clock that comes with that tributary into the clock that drives frame generation in a higher-order multiplexer. Each tributary input of a multiplexer has its own instance. A group of four DS1 inputs or three E1 inputs therefore uses four or three instances, each 16 bits deep. A DS2 feeding a DS3 multiplexer uses an instance 8 bits deep.

The frame generator pulses `stuff_req` one bit before each justification slot. The block answers on the following read-clock edge. `stuff_ind` high means the slot must carry a stuff bit. `stuff_ind` low means the slot carries data, which the frame generator then fetches with `rd_en`. The answer depends only on the fill level the read side sees. When the buffer runs below half full, the block asks for a stuff so that it can refill. This level-driven control lets the buffer absorb a steady offset of about ±130 ppm and several unit intervals of jitter.

The two pointers cross between the clock domains in Gray code through two-stage synchronizers. When the buffer overruns or runs dry, the side that detects it raises a sticky error flag and moves its own pointer to half depth from the other side's pointer.

Top module: `bitstuff_fifo`

## Requirements
- R1: After reset is released, `rd_bit`, `stuff_vld`, `stuff_ind`, `ovf_err` and `unf_err` are all 0.
- R2: Bits come out of `rd_bit` in the order they were written on `wr_bit`.
- R3: A `stuff_req` pulse gives a one-cycle `stuff_vld` pulse on the next `rd_clk` edge. `stuff_ind` is then 1 (stuff, no data) when the fill level seen by the read side is below DEPTH/2.
- R4: When that fill level is DEPTH/2 or more, the same answer carries `stuff_ind` = 0 (take data). `stuff_ind` holds its value until the next request.
- R5: An `rd_en` pulse with the buffer not empty presents the oldest stored bit on `rd_bit` from the next `rd_clk` edge and removes that bit from the buffer.
- R6: When `stuff_req` and `rd_en` fall in the same cycle, the decision uses the fill level from before that read.
- R7: An `rd_en` while the read side sees the buffer empty sets `unf_err`, drives `rd_bit` to 0 and moves the read pointer so that the fill level becomes DEPTH/2.
- R8: A `wr_en` while the write side sees the buffer full (DEPTH bits) sets `ovf_err` and drops the bit. The write pointer moves to DEPTH/2 past the read pointer, so the oldest DEPTH/2 stored bits are kept and read out in order.
- R9: `ovf_err` and `unf_err` stay set until reset.
- R10: DEPTH is a parameter, 16 by default for DS1/E1 and 8 for DS2. The stuff threshold follows it: an 8-deep instance asks for a stuff at a fill level of 3 and takes data at 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Tributary clock |
| rd_clk | input | 1 | Frame-generation clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_en | input | 1 | Write strobe, one bit per pulse |
| wr_bit | input | 1 | Tributary data bit |
| rd_en | input | 1 | Read strobe, one bit per pulse |
| rd_bit | output | 1 | Data bit delivered to the frame |
| stuff_req | input | 1 | Request for a justification decision |
| stuff_vld | output | 1 | Decision strobe, one cycle after the request |
| stuff_ind | output | 1 | 1 = stuff the slot, 0 = slot carries data |
| ovf_err | output | 1 | Sticky overflow flag |
| unf_err | output | 1 | Sticky underflow flag |

## Verification
A justification request and a data read can arrive on the same read-clock edge. The bench provokes this by filling the buffer to exactly DEPTH/2 and then pulsing `stuff_req` and `rd_en` together. The decision must be "take data", which reflects the fill level before the read, while `rd_bit` shows the expected oldest bit. A second request must then return "stuff", because the fill has dropped to DEPTH/2 − 1.

// File: rtl/bitstuff_fifo.sv
`timescale 1ns/1ps
module bitstuff_fifo #(
  parameter int DEPTH = 16
) (
  input  logic wr_clk,
  input  logic rd_clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic rd_en,
  output logic rd_bit,
  input  logic stuff_req,
  output logic stuff_vld,
  output logic stuff_ind,
  output logic ovf_err,
  output logic unf_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DEPTH-1:0] store;

  // write domain
  logic [PW-1:0] wptr, wptr_nxt, wgray, rg_s1, rg_s2, rsync_bin;
  logic wr_full;

  assign rsync_bin = from_gray(rg_s2);
  assign wr_full   = (wptr - rsync_bin) == FULL;

  always_comb begin
    wptr_nxt = wptr;
    if (wr_en) wptr_nxt = wr_full ? rsync_bin + HALF : wptr + 1'b1;
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      wgray   <= '0;
      rg_s1   <= '0;
      rg_s2   <= '0;
      ovf_err <= 1'b0;
    end else begin
      wptr  <= wptr_nxt;
      wgray <= to_gray(wptr_nxt);
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_en && wr_full) ovf_err <= 1'b1;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_en && !wr_full) store[wptr[AW-1:0]] <= wr_bit;
  end

  // read domain
  logic [PW-1:0] rptr, rptr_nxt, rgray, wg_s1, wg_s2, wsync_bin, rd_fill;
  logic rd_empty;

  assign wsync_bin = from_gray(wg_s2);
  assign rd_fill   = wsync_bin - rptr;
  assign rd_empty  = rd_fill == '0;

  always_comb begin
    rptr_nxt = rptr;
    if (rd_en) rptr_nxt = rd_empty ? wsync_bin - HALF : rptr + 1'b1;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr      <= '0;
      rgray     <= '0;
      wg_s1     <= '0;
      wg_s2     <= '0;
      rd_bit    <= 1'b0;
      unf_err   <= 1'b0;
      stuff_vld <= 1'b0;
      stuff_ind <= 1'b0;
    end else begin
      rptr      <= rptr_nxt;
      rgray     <= to_gray(rptr_nxt);
      wg_s1     <= wgray;
      wg_s2     <= wg_s1;
      stuff_vld <= stuff_req;
      if (stuff_req) stuff_ind <= rd_fill < HALF;
      if (rd_en) begin
        if (rd_empty) begin
          unf_err <= 1'b1;
          rd_bit  <= 1'b0;
        end else begin
          rd_bit  <= store[rptr[AW-1:0]];
        end
      end
    end
  end

  // R5
  always_ff @(posedge rd_clk) begin
    if (rst_n) fill_bound_chk: assert (rd_fill <= FULL);
  end

  // R3
  stuff_ack_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    stuff_req |=> stuff_vld);

  // R7
  underflow_flag_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en && rd_empty) |=> (unf_err && !rd_bit));

  // R8
  overflow_flag_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && wr_full) |=> ovf_err);

  // R9
  unf_sticky_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    unf_err |=> unf_err);

  // R9
  ovf_sticky_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
endmodule

// File: tb/bitstuff_fifo_tb_top.sv
`timescale 1ns/1ps
module bitstuff_fifo_tb_top;
  logic rd_clk = 1'b0, wr_clk = 1'b0, rst_n = 1'b0;
  always #2.5 rd_clk = ~rd_clk;
  initial begin #1.7; forever #2.5 wr_clk = ~wr_clk; end

  logic wr_en = 0, wr_bit = 0, rd_en = 0, stuff_req = 0;
  logic rd_bit, stuff_vld, stuff_ind, ovf_err, unf_err;
  logic w8_en = 0, w8_bit = 0, r8_en = 0, s8_req = 0;
  logic r8_bit, s8_vld, s8_ind, o8_err, u8_err;

  bitstuff_fifo #(.DEPTH(16)) dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit),
    .rd_en(rd_en), .rd_bit(rd_bit), .stuff_req(stuff_req), .stuff_vld(stuff_vld),
    .stuff_ind(stuff_ind), .ovf_err(ovf_err), .unf_err(unf_err));

  bitstuff_fifo #(.DEPTH(8)) dut8_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(w8_en), .wr_bit(w8_bit),
    .rd_en(r8_en), .rd_bit(r8_bit), .stuff_req(s8_req), .stuff_vld(s8_vld),
    .stuff_ind(s8_ind), .ovf_err(o8_err), .unf_err(u8_err));

  int n_chk = 0, n_bad = 0;
  bit model[$];
  logic [15:0] lfsr = 16'hACE1;

  // {bits written, bits read, expected stuff_ind}
  localparam int VEC [0:7][0:2] = '{
    '{3, 0, 1}, '{6, 2, 0}, '{0, 0, 1}, '{1, 4, 0},
    '{10, 13, 0}, '{7, 8, 0}, '{0, 0, 1}, '{16, 16, 0}};

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr_en = 1; wr_bit = lfsr[0];
      model.push_back(lfsr[0]);
    end
    @(negedge wr_clk); wr_en = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
  endtask

  task automatic ask(input string req, input logic exp);
    @(negedge rd_clk); stuff_req = 1;
    @(negedge rd_clk); stuff_req = 0;
    check(req, stuff_vld, 1'b1);
    check(req, stuff_ind, exp);
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk); rd_en = 1;
      @(negedge rd_clk); rd_en = 0;
      check("R2/R5 read order", rd_bit, model.pop_front());
    end
  endtask

  task automatic do_reset();
    rst_n = 0; model.delete();
    repeat (3) @(negedge rd_clk);
    rst_n = 1;
    repeat (2) @(negedge rd_clk);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    check("R1 rd_bit", rd_bit, 0);
    check("R1 stuff_vld", stuff_vld, 0);
    check("R1 stuff_ind", stuff_ind, 0);
    check("R1 ovf_err", ovf_err, 0);
    check("R1 unf_err", unf_err, 0);

    // R3 / R4 table
    for (int v = 0; v < 8; v++) begin
      write_n(VEC[v][0]);
      settle();
      ask(VEC[v][2] != 0 ? "R3 stuff below half" : "R4 data at half or above", VEC[v][2] != 0);
      read_n(VEC[v][1]);
      settle();
    end

    // R6 request and read in the same cycle at fill = half
    write_n(8); settle();
    @(negedge rd_clk); stuff_req = 1; rd_en = 1;
    @(negedge rd_clk); stuff_req = 0; rd_en = 0;
    check("R6 decision on pre-read fill", stuff_ind, 0);
    check("R6 read bit", rd_bit, model.pop_front());
    ask("R6 fill now below half", 1);
    read_n(7); settle();

    // R7 underflow
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
    check("R7 unf_err", unf_err, 1);
    check("R7 rd_bit zero", rd_bit, 0);
    ask("R7 recentered to half", 0);
    repeat (8) begin
      @(negedge rd_clk); rd_en = 1;
      @(negedge rd_clk); rd_en = 0;
    end
    check("R9 unf_err sticky", unf_err, 1);
    check("R7 no overflow", ovf_err, 0);

    // R8 overflow
    do_reset();
    check("R1 flags cleared", unf_err, 0);
    write_n(16); settle();
    @(negedge wr_clk); wr_en = 1; wr_bit = 1;
    @(negedge wr_clk); wr_en = 0;
    check("R8 ovf_err", ovf_err, 1);
    while (model.size() > 8) void'(model.pop_back());
    settle();
    ask("R8 recentered to half", 0);
    read_n(8);
    settle();
    ask("R8 empty after kept bits", 1);
    check("R9 ovf_err sticky", ovf_err, 1);

    // R10 depth 8
    for (int i = 0; i < 4; i++) begin
      @(negedge wr_clk); w8_en = 1; w8_bit = i[0];
      @(negedge wr_clk); w8_en = 0;
      if (i == 2) begin
        settle();
        @(negedge rd_clk); s8_req = 1;
        @(negedge rd_clk); s8_req = 0;
        check("R10 depth8 fill 3 stuff", s8_ind, 1);
      end
    end
    settle();
    @(negedge rd_clk); s8_req = 1;
    @(negedge rd_clk); s8_req = 0;
    check("R10 depth8 fill 4 data", s8_ind, 0);
    check("R10 depth8 vld", s8_vld, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule